// File: doc/BRIEF.md
# Round-Robin Thread-Block Dispatcher

This block sits in front of a cluster of compute cores. It gives each core whole thread blocks of a kernel and tracks when those blocks and kernels finish. A core that holds no kernel and has no live threads asks a kernel scheduler for work. When the scheduler grants a kernel, the core is bound to it. The grant carries the kernel ID, the maximum number of blocks per core and the number of threads per block. From then on the core takes only blocks of that kernel.

Each cycle the dispatcher visits the cores in rotating order, starting one past the core that last received a block. It issues at most one block, to the first core whose kernel still has blocks waiting and which still has room. The block is placed in a free context on that core, and the context's live-thread count is loaded with the kernel's threads per block. Each thread exit lowers the count of its context. When a count reaches zero, the barrier of that context is released. When the last block on a core finishes, the core is unbound. The last core to drain a kernel that has no blocks left reports the kernel ID as finished.

Top module: `blk_dispatch`

## Requirements
- R1: Cores are visited in the order (P+1+i) mod C for i = 0..C-1, where P is the last core that received a block. At most one block is issued per cycle (issue_o), to the first eligible core in that order, and P then becomes that core.
- R2: kreq_o is high when some core is unbound and has no live threads. kreq_core_o names the first such core in the same visiting order. A grant (kgrant_i high in that cycle) binds that core from the next cycle, with the granted ID, block maximum (1 to the context count) and threads per block. Without a grant the core stays unbound.
- R3: A core is eligible only if it is bound, the bit of its kernel in kblk_left_i (bit k for kernel k) is set, and its number of active blocks is below its block maximum.
- R4: An issued block takes the lowest-numbered context whose live-thread count is zero, among the contexts below the block maximum. It is reported on issue_ctx_o and issue_kid_o, and its count is set to the threads per block, so that many exits free it.
- R5: A thread exit (exit_i with a core and a context) lowers that context's count by one. An exit on a count that is already zero raises err_o in that cycle, leaves every count unchanged and frees nothing.
- R6: The exit that takes a count to zero raises bar_free_o in the same cycle, with that core and context. The core's active block count drops by one, and the context can be reused from the next cycle.
- R7: When a core's last active block finishes, the core is unbound from the next cycle and its kernel's running-core count drops by one. If that count reaches zero while the kernel's kblk_left_i bit is clear, kdone_o is raised in the same cycle with the kernel ID on kdone_id_o.
- R8: A kernel still bound to another core is not reported as finished when one of its cores drains.
- R9: After reset no core is bound and no block is live. The visiting order starts at core 0, so kreq_o is high with kreq_core_o = 0 and issue_o, bar_free_o, kdone_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kreq_o | output | 1 | A core is asking the scheduler for a kernel |
| kreq_core_o | output | CORE_W | Core that is asking |
| kgrant_i | input | 1 | Scheduler grants a kernel this cycle |
| kgrant_id_i | input | KID_W | Granted kernel ID |
| kgrant_max_i | input | ACT_W | Maximum blocks per core for the granted kernel |
| kgrant_tpb_i | input | THR_W | Threads per block of the granted kernel |
| kblk_left_i | input | NUM_KERNELS | Bit k set: kernel k still has blocks to dispatch |
| issue_o | output | 1 | A block is issued this cycle |
| issue_core_o | output | CORE_W | Core that receives the block |
| issue_ctx_o | output | CTX_W | Context that holds the block |
| issue_kid_o | output | KID_W | Kernel of the issued block |
| exit_i | input | 1 | A thread exits this cycle |
| exit_core_i | input | CORE_W | Core of the exiting thread |
| exit_ctx_i | input | CTX_W | Context owning the exiting warp |
| bar_free_o | output | 1 | A block finished; release its barrier |
| bar_free_core_o | output | CORE_W | Core of the finished block |
| bar_free_ctx_o | output | CTX_W | Context of the finished block |
| kdone_o | output | 1 | A kernel has finished |
| kdone_id_o | output | KID_W | ID of the finished kernel |
| err_o | output | 1 | A thread exit hit a context with a zero count |

## Verification
The bench uses the default build: four cores, four block contexts per core, four kernel IDs and a 4-bit thread count. With four cores the visiting order wraps around the last core. Several kernels can be bound at once, each at its own block maximum of one or two. One kernel can be spread over two cores, so the last drainer is distinguishable from the first. Exits on unbound cores and on contexts above the block maximum exercise the error path without touching live counts.

// File: rtl/bd_pkg.sv
package bd_pkg;

  // position visited at step 'step' when the rotation last stopped at 'base'
  function automatic int unsigned rot_pos(input int unsigned base,
                                          input int unsigned step,
                                          input int unsigned n);
    return (base + 32'd1 + step) % n;
  endfunction

endpackage

// File: rtl/bd_rr_pick.sv
module bd_rr_pick #(
  parameter int unsigned N = 4,
  parameter int unsigned W = 2
) (
  input  logic [N-1:0] req_i,
  input  logic [W-1:0] base_i,
  output logic         hit_o,
  output logic [W-1:0] idx_o
);
  int unsigned pos;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    pos   = 0;
    for (int unsigned j = 0; j < N; j++) begin
      pos = bd_pkg::rot_pos(int'(base_i), j, N);
      if (!hit_o && req_i[pos]) begin
        hit_o = 1'b1;
        idx_o = W'(pos);
      end
    end
  end
endmodule

// File: rtl/bd_core_slot.sv
module bd_core_slot #(
  parameter int unsigned CTX   = 4,
  parameter int unsigned CTX_W = 2,
  parameter int unsigned ACT_W = 3,
  parameter int unsigned KID_W = 2,
  parameter int unsigned THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bind_en_i,
  input  logic [KID_W-1:0] bind_kid_i,
  input  logic [ACT_W-1:0] bind_max_i,
  input  logic [THR_W-1:0] bind_tpb_i,
  input  logic             issue_en_i,
  input  logic             exit_en_i,
  input  logic [CTX_W-1:0] exit_ctx_i,
  output logic             bound_o,
  output logic [KID_W-1:0] kid_o,
  output logic             want_o,
  output logic             room_o,
  output logic [CTX_W-1:0] free_ctx_o,
  output logic             blk_done_o,
  output logic             empty_o,
  output logic             underflow_o,
  output logic [ACT_W-1:0] active_o,
  output logic [ACT_W-1:0] max_o
);
  logic             bound_q;
  logic [KID_W-1:0] kid_q;
  logic [ACT_W-1:0] max_q;
  logic [THR_W-1:0] tpb_q;
  logic [ACT_W-1:0] act_q;
  logic [THR_W-1:0] cnt_q [CTX];

  logic [THR_W-1:0] sel_cnt;
  logic             dec;
  logic             idle;
  logic             found;

  // lowest free context under the block limit; idle when no context is live
  always_comb begin
    idle       = 1'b1;
    found      = 1'b0;
    free_ctx_o = '0;
    for (int i = 0; i < int'(CTX); i++) begin
      if (cnt_q[i] != '0) idle = 1'b0;
      if (!found && (ACT_W'(i) < max_q) && (cnt_q[i] == '0)) begin
        found      = 1'b1;
        free_ctx_o = CTX_W'(i);
      end
    end
  end

  assign sel_cnt     = cnt_q[exit_ctx_i];
  assign underflow_o = exit_en_i && (sel_cnt == '0);
  assign dec         = exit_en_i && (sel_cnt != '0);
  assign blk_done_o  = dec && (sel_cnt == THR_W'(1));
  assign empty_o     = blk_done_o && (act_q == ACT_W'(1)) && !issue_en_i;
  assign room_o      = bound_q && (act_q < max_q);
  assign want_o      = !bound_q && idle;
  assign bound_o     = bound_q;
  assign kid_o       = kid_q;
  assign active_o    = act_q;
  assign max_o       = max_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bound_q <= 1'b0;
      kid_q   <= '0;
      max_q   <= '0;
      tpb_q   <= '0;
      act_q   <= '0;
      for (int i = 0; i < int'(CTX); i++) cnt_q[i] <= '0;
    end else begin
      if (bind_en_i) begin
        bound_q <= 1'b1;
        kid_q   <= bind_kid_i;
        max_q   <= bind_max_i;
        tpb_q   <= bind_tpb_i;
      end else if (empty_o) begin
        bound_q <= 1'b0;
      end
      act_q <= act_q + ACT_W'(issue_en_i) - ACT_W'(blk_done_o);
      for (int i = 0; i < int'(CTX); i++) begin
        if (issue_en_i && (free_ctx_o == CTX_W'(i)))
          cnt_q[i] <= tpb_q;
        else if (dec && (exit_ctx_i == CTX_W'(i)))
          cnt_q[i] <= cnt_q[i] - THR_W'(1);
      end
    end
  end
endmodule

// File: rtl/bd_kernel_track.sv
module bd_kernel_track #(
  parameter int unsigned NK    = 4,
  parameter int unsigned KID_W = 2,
  parameter int unsigned RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bind_en_i,
  input  logic [KID_W-1:0] bind_kid_i,
  input  logic             drop_en_i,
  input  logic [KID_W-1:0] drop_kid_i,
  input  logic [NK-1:0]    left_i,
  output logic             done_o,
  output logic [KID_W-1:0] done_id_o
);
  logic [RUN_W-1:0] run_q [NK];
  logic [RUN_W-1:0] run_d [NK];

  always_comb begin
    for (int k = 0; k < int'(NK); k++)
      run_d[k] = run_q[k]
               + RUN_W'(bind_en_i && (bind_kid_i == KID_W'(k)))
               - RUN_W'(drop_en_i && (drop_kid_i == KID_W'(k)));
  end

  assign done_o    = drop_en_i && (run_d[drop_kid_i] == '0) && !left_i[drop_kid_i];
  assign done_id_o = drop_kid_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NK); k++) run_q[k] <= '0;
    end else begin
      for (int k = 0; k < int'(NK); k++) run_q[k] <= run_d[k];
    end
  end
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch #(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned NUM_CTX     = 4,
  parameter int unsigned NUM_KERNELS = 4,
  parameter int unsigned THR_W       = 4,
  localparam int unsigned CORE_W = $clog2(NUM_CORES),
  localparam int unsigned CTX_W  = $clog2(NUM_CTX),
  localparam int unsigned KID_W  = $clog2(NUM_KERNELS),
  localparam int unsigned ACT_W  = $clog2(NUM_CTX + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   kreq_o,
  output logic [CORE_W-1:0]      kreq_core_o,
  input  logic                   kgrant_i,
  input  logic [KID_W-1:0]       kgrant_id_i,
  input  logic [ACT_W-1:0]       kgrant_max_i,
  input  logic [THR_W-1:0]       kgrant_tpb_i,
  input  logic [NUM_KERNELS-1:0] kblk_left_i,
  output logic                   issue_o,
  output logic [CORE_W-1:0]      issue_core_o,
  output logic [CTX_W-1:0]       issue_ctx_o,
  output logic [KID_W-1:0]       issue_kid_o,
  input  logic                   exit_i,
  input  logic [CORE_W-1:0]      exit_core_i,
  input  logic [CTX_W-1:0]       exit_ctx_i,
  output logic                   bar_free_o,
  output logic [CORE_W-1:0]      bar_free_core_o,
  output logic [CTX_W-1:0]       bar_free_ctx_o,
  output logic                   kdone_o,
  output logic [KID_W-1:0]       kdone_id_o,
  output logic                   err_o
);
  localparam int unsigned RUN_W = $clog2(NUM_CORES + 1);

  logic [NUM_CORES-1:0] want_c, room_c, elig_c, bound_c;
  logic [NUM_CORES-1:0] blkdone_c, empty_c, under_c;
  logic [NUM_CORES-1:0] bind_c, issue_c, exit_c;
  logic [KID_W-1:0]     kid_c  [NUM_CORES];
  logic [CTX_W-1:0]     free_c [NUM_CORES];
  logic [ACT_W-1:0]     act_c  [NUM_CORES];
  logic [ACT_W-1:0]     max_c  [NUM_CORES];
  logic [NUM_CORES*ACT_W-1:0] act_flat, max_flat;

  logic [CORE_W-1:0] ptr_q;
  logic              pick_hit, req_hit;
  logic [CORE_W-1:0] pick_idx, req_idx;
  logic              drop_en;

  // named events for the checker
  logic bind_evt;
  assign bind_evt = req_hit && kgrant_i;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign bind_c[c]  = bind_evt && (req_idx == CORE_W'(c));
    assign issue_c[c] = pick_hit && (pick_idx == CORE_W'(c));
    assign exit_c[c]  = exit_i && (exit_core_i == CORE_W'(c));
    assign elig_c[c]  = room_c[c] && kblk_left_i[kid_c[c]];
    assign act_flat[c*ACT_W +: ACT_W] = act_c[c];
    assign max_flat[c*ACT_W +: ACT_W] = max_c[c];

    bd_core_slot #(
      .CTX(NUM_CTX), .CTX_W(CTX_W), .ACT_W(ACT_W), .KID_W(KID_W), .THR_W(THR_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .bind_en_i   (bind_c[c]),
      .bind_kid_i  (kgrant_id_i),
      .bind_max_i  (kgrant_max_i),
      .bind_tpb_i  (kgrant_tpb_i),
      .issue_en_i  (issue_c[c]),
      .exit_en_i   (exit_c[c]),
      .exit_ctx_i  (exit_ctx_i),
      .bound_o     (bound_c[c]),
      .kid_o       (kid_c[c]),
      .want_o      (want_c[c]),
      .room_o      (room_c[c]),
      .free_ctx_o  (free_c[c]),
      .blk_done_o  (blkdone_c[c]),
      .empty_o     (empty_c[c]),
      .underflow_o (under_c[c]),
      .active_o    (act_c[c]),
      .max_o       (max_c[c])
    );
  end

  bd_rr_pick #(.N(NUM_CORES), .W(CORE_W)) u_issue_pick (
    .req_i (elig_c), .base_i (ptr_q), .hit_o (pick_hit), .idx_o (pick_idx)
  );

  bd_rr_pick #(.N(NUM_CORES), .W(CORE_W)) u_req_pick (
    .req_i (want_c), .base_i (ptr_q), .hit_o (req_hit), .idx_o (req_idx)
  );

  assign drop_en = |empty_c;

  bd_kernel_track #(.NK(NUM_KERNELS), .KID_W(KID_W), .RUN_W(RUN_W)) u_ktrack (
    .clk        (clk),
    .rst_n      (rst_n),
    .bind_en_i  (bind_evt),
    .bind_kid_i (kgrant_id_i),
    .drop_en_i  (drop_en),
    .drop_kid_i (kid_c[exit_core_i]),
    .left_i     (kblk_left_i),
    .done_o     (kdone_o),
    .done_id_o  (kdone_id_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_q <= CORE_W'(NUM_CORES - 1);
    else if (pick_hit) ptr_q <= pick_idx;
  end

  assign kreq_o          = req_hit;
  assign kreq_core_o     = req_idx;
  assign issue_o         = pick_hit;
  assign issue_core_o    = pick_idx;
  assign issue_ctx_o     = free_c[pick_idx];
  assign issue_kid_o     = kid_c[pick_idx];
  assign bar_free_o      = |blkdone_c;
  assign bar_free_core_o = exit_core_i;
  assign bar_free_ctx_o  = exit_ctx_i;
  assign err_o           = |under_c;
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int unsigned NUM_CORES   = 4,
  parameter int unsigned NUM_KERNELS = 4,
  parameter int unsigned CORE_W      = 2,
  parameter int unsigned KID_W       = 2,
  parameter int unsigned ACT_W       = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       kreq_o,
  input logic [CORE_W-1:0]          kreq_core_o,
  input logic [NUM_KERNELS-1:0]     kblk_left_i,
  input logic                       issue_o,
  input logic [CORE_W-1:0]          issue_core_o,
  input logic [KID_W-1:0]           issue_kid_o,
  input logic                       exit_i,
  input logic                       bar_free_o,
  input logic                       kdone_o,
  input logic                       err_o,
  input logic [NUM_CORES-1:0]       bound_c,
  input logic [NUM_CORES*ACT_W-1:0] act_flat,
  input logic [NUM_CORES*ACT_W-1:0] max_flat
);
  AST_ISSUE_HAS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> kblk_left_i[issue_kid_o]); // R3
  AST_ISSUE_TO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> bound_c[issue_core_o]); // R1
  AST_REQ_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_o && kreq_o) |-> (issue_core_o != kreq_core_o)); // R2
  AST_REQ_UNBOUND: assert property (@(posedge clk) disable iff (!rst_n)
    kreq_o |-> !bound_c[kreq_core_o]); // R2
  AST_ERR_NEEDS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (exit_i && !bar_free_o)); // R5
  AST_FREE_NEEDS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    bar_free_o |-> exit_i); // R6
  AST_DONE_WITH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    kdone_o |-> bar_free_o); // R7

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    AST_ACT_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      bound_c[c] |-> (act_flat[c*ACT_W +: ACT_W] <= max_flat[c*ACT_W +: ACT_W])); // R3
    AST_UNBOUND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !bound_c[c] |-> (act_flat[c*ACT_W +: ACT_W] == '0)); // R7
  end
endmodule

bind blk_dispatch bd_checker #(
  .NUM_CORES(NUM_CORES), .NUM_KERNELS(NUM_KERNELS),
  .CORE_W(CORE_W), .KID_W(KID_W), .ACT_W(ACT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .kreq_o       (kreq_o),
  .kreq_core_o  (kreq_core_o),
  .kblk_left_i  (kblk_left_i),
  .issue_o      (issue_o),
  .issue_core_o (issue_core_o),
  .issue_kid_o  (issue_kid_o),
  .exit_i       (exit_i),
  .bar_free_o   (bar_free_o),
  .kdone_o      (kdone_o),
  .err_o        (err_o),
  .bound_c      (bound_c),
  .act_flat     (act_flat),
  .max_flat     (max_flat)
);

// File: tb/tb_blk_dispatch.sv
module tb_blk_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 27;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kreq_o;
  logic [1:0] kreq_core_o;
  logic       kgrant_i = 1'b0;
  logic [1:0] kgrant_id_i = '0;
  logic [2:0] kgrant_max_i = '0;
  logic [3:0] kgrant_tpb_i = '0;
  logic [3:0] kblk_left_i = '0;
  logic       issue_o;
  logic [1:0] issue_core_o, issue_ctx_o, issue_kid_o;
  logic       exit_i = 1'b0;
  logic [1:0] exit_core_i = '0, exit_ctx_i = '0;
  logic       bar_free_o;
  logic [1:0] bar_free_core_o, bar_free_ctx_o;
  logic       kdone_o;
  logic [1:0] kdone_id_o;
  logic       err_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_dispatch dut (
    .clk(clk), .rst_n(rst_n), .kreq_o(kreq_o), .kreq_core_o(kreq_core_o),
    .kgrant_i(kgrant_i), .kgrant_id_i(kgrant_id_i), .kgrant_max_i(kgrant_max_i),
    .kgrant_tpb_i(kgrant_tpb_i), .kblk_left_i(kblk_left_i), .issue_o(issue_o),
    .issue_core_o(issue_core_o), .issue_ctx_o(issue_ctx_o), .issue_kid_o(issue_kid_o),
    .exit_i(exit_i), .exit_core_i(exit_core_i), .exit_ctx_i(exit_ctx_i),
    .bar_free_o(bar_free_o), .bar_free_core_o(bar_free_core_o),
    .bar_free_ctx_o(bar_free_ctx_o), .kdone_o(kdone_o), .kdone_id_o(kdone_id_o),
    .err_o(err_o)
  );

  // expected vector: {req,reqc,iss,issc,issx,issk,bar,barc,barx,done,did,err}
  typedef struct packed {
    logic       gnt;
    logic [1:0] gid;
    logic [2:0] gmax;
    logic [3:0] gtpb;
    logic [3:0] left;
    logic       ex;
    logic [1:0] exc;
    logic [1:0] exx;
    logic [18:0] exp;
    logic [3:0] tag;
  } row_t;

  function automatic row_t mk(
    input logic gnt, input logic [1:0] gid, input logic [2:0] gmax, input logic [3:0] gtpb,
    input logic [3:0] left, input logic ex, input logic [1:0] exc, input logic [1:0] exx,
    input logic req, input logic [1:0] reqc,
    input logic iss, input logic [1:0] issc, input logic [1:0] issx, input logic [1:0] issk,
    input logic bar, input logic [1:0] barc, input logic [1:0] barx,
    input logic done, input logic [1:0] did, input logic err, input logic [3:0] tag);
    row_t r;
    r.gnt = gnt; r.gid = gid; r.gmax = gmax; r.gtpb = gtpb; r.left = left;
    r.ex = ex; r.exc = exc; r.exx = exx; r.tag = tag;
    r.exp = {req, reqc, iss, issc, issx, issk, bar, barc, barx, done, did, err};
    return r;
  endfunction

  localparam row_t TBL [NROWS] = '{
    mk(0,0,0,0, 4'b0000, 0,0,0, 1,0, 0,0,0,0, 0,0,0, 0,0, 0, 9), // R9 reset: core 0 asks
    mk(1,1,2,2, 4'b0010, 0,0,0, 1,0, 0,0,0,0, 0,0,0, 0,0, 0, 2), // R2 grant k1 to core 0
    mk(0,0,0,0, 4'b0010, 0,0,0, 1,1, 1,0,0,1, 0,0,0, 0,0, 0, 1), // R1 core0 ctx0
    mk(0,0,0,0, 4'b0010, 0,0,0, 1,1, 1,0,1,1, 0,0,0, 0,0, 0, 4), // R4 next ctx1
    mk(1,2,1,1, 4'b0010, 0,0,0, 1,1, 0,0,0,0, 0,0,0, 0,0, 0, 3), // R3 core0 full
    mk(0,0,0,0, 4'b0110, 0,0,0, 1,2, 1,1,0,2, 0,0,0, 0,0, 0, 1), // R1 core1 k2
    mk(0,0,0,0, 4'b0010, 1,0,0, 1,2, 0,0,0,0, 0,0,0, 0,0, 0, 5), // R5 2->1
    mk(0,0,0,0, 4'b0010, 1,0,0, 1,2, 0,0,0,0, 1,0,0, 0,0, 0, 6), // R6 1->0 frees
    mk(0,0,0,0, 4'b0010, 0,0,0, 1,2, 1,0,0,1, 0,0,0, 0,0, 0, 4), // R4 reuse ctx0
    mk(0,0,0,0, 4'b0000, 1,1,0, 1,2, 0,0,0,0, 1,1,0, 1,2, 0, 7), // R7 k2 done
    mk(0,0,0,0, 4'b0000, 1,2,0, 1,1, 0,0,0,0, 0,0,0, 0,0, 1, 5), // R5 underflow, R7 core1 free
    mk(0,0,0,0, 4'b0000, 1,0,2, 1,1, 0,0,0,0, 0,0,0, 0,0, 1, 5), // R5 ctx above max
    mk(1,3,1,1, 4'b1000, 0,0,0, 1,1, 0,0,0,0, 0,0,0, 0,0, 0, 2), // R2 k3 to core1
    mk(1,3,1,1, 4'b1000, 0,0,0, 1,2, 1,1,0,3, 0,0,0, 0,0, 0, 1), // R1 k3 to core2 too
    mk(0,0,0,0, 4'b1000, 0,0,0, 1,3, 1,2,0,3, 0,0,0, 0,0, 0, 1), // R1 rotation to core2
    mk(0,0,0,0, 4'b0000, 1,1,0, 1,3, 0,0,0,0, 1,1,0, 0,0, 0, 8), // R8 first drainer silent
    mk(0,0,0,0, 4'b0000, 1,2,0, 1,3, 0,0,0,0, 1,2,0, 1,3, 0, 7), // R7 last drainer
    mk(0,0,0,0, 4'b0000, 1,0,1, 1,3, 0,0,0,0, 0,0,0, 0,0, 0, 5), // R5 count kept by err
    mk(0,0,0,0, 4'b0000, 1,0,1, 1,3, 0,0,0,0, 1,0,1, 0,0, 0, 6), // R6
    mk(0,0,0,0, 4'b0000, 1,0,0, 1,3, 0,0,0,0, 0,0,0, 0,0, 0, 5), // R5
    mk(0,0,0,0, 4'b0000, 1,0,0, 1,3, 0,0,0,0, 1,0,0, 1,1, 0, 7), // R7 k1 done
    mk(1,0,2,1, 4'b0001, 0,0,0, 1,3, 0,0,0,0, 0,0,0, 0,0, 0, 2), // R2 k0 to core3
    mk(1,0,2,1, 4'b0001, 0,0,0, 1,0, 1,3,0,0, 0,0,0, 0,0, 0, 1), // R1 core3
    mk(1,0,2,1, 4'b0001, 0,0,0, 1,1, 1,0,0,0, 0,0,0, 0,0, 0, 1), // R1 wrap to core0
    mk(1,0,2,1, 4'b0001, 0,0,0, 1,2, 1,1,0,0, 0,0,0, 0,0, 0, 1), // R1 core1
    mk(0,0,0,0, 4'b0001, 0,0,0, 0,0, 1,2,0,0, 0,0,0, 0,0, 0, 2), // R2 none idle
    mk(0,0,0,0, 4'b0001, 0,0,0, 0,0, 1,3,1,0, 0,0,0, 0,0, 0, 1)  // R1 back to core3 ctx1
  };

  function automatic logic [18:0] observed();
    return {kreq_o, kreq_o ? kreq_core_o : 2'd0,
            issue_o, issue_o ? issue_core_o : 2'd0, issue_o ? issue_ctx_o : 2'd0,
            issue_o ? issue_kid_o : 2'd0,
            bar_free_o, bar_free_o ? bar_free_core_o : 2'd0, bar_free_o ? bar_free_ctx_o : 2'd0,
            kdone_o, kdone_o ? kdone_id_o : 2'd0, err_o};
  endfunction

  task automatic check(input logic [18:0] exp, input int tag, input int id);
    logic [18:0] got;
    got = observed();
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d step %0d: actual %b expected %b", tag, id, got, exp);
    end
  endtask

  task automatic apply(input row_t r);
    kgrant_i = r.gnt; kgrant_id_i = r.gid; kgrant_max_i = r.gmax; kgrant_tpb_i = r.gtpb;
    kblk_left_i = r.left; exit_i = r.ex; exit_core_i = r.exc; exit_ctx_i = r.exx;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int r = 0; r < NROWS; r++) begin
      @(posedge clk);
      #1 apply(TBL[r]);
      @(negedge clk);
      check(TBL[r].exp, int'(TBL[r].tag), r);
    end
    // directed R9: reset while bound, blocks still waiting
    @(posedge clk);
    #1 rst_n = 1'b0;
    apply(mk(0,0,0,0, 4'b0001, 0,0,0, 0,0, 0,0,0,0, 0,0,0, 0,0, 0, 9));
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(19'b1_00_0_00_00_00_0_00_00_0_00_0, 9, 100); // R9 back to core 0, no issue
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule